// File: doc/BRIEF.md
# Seeded Coset Kernel Builder

This block produces four 16-bit coset kernels for a multi-level-cell write encoder. It builds them from the encrypted data word that is about to be written, so no kernel table has to be stored. The 64-bit input word holds 32 two-bit cell symbols. The encoder never alters the high digit of a symbol, because write energy does not depend on it. The encoder and the decoder therefore both see the same 32 high digits, and both can rebuild identical kernels from them.

The high digits are gathered into two 16-bit base vectors. Each base vector is then combined with a small set of 2-bit masks. Each mask is repeated across the whole vector and XORed in. The top bit of every mask is held at zero, so two kernels that come from the same base can never be bitwise complements of each other.

The block is purely combinational. Its kernels follow the input word in the same cycle.

Top module: `coset_kernel_gen`

## Requirements
- R1: Kernel k (bits 16k+15..16k of `kernels_o`, k = 0..3) equals base vector k/2 XORed with mask k%2 repeated over each 2-bit slice. Mask 0 is 00 and mask 1 is 01 (bit 0 of each slice set), so kernel 2b+1 = kernel 2b XOR 16'h5555.
- R2: Bit j of base vector b equals bit 2(16b+j)+1 of `word_i`: the high digit of symbol 16b+j. Base 0 uses symbols 0..15 and base 1 uses symbols 16..31.
- R3: The low digit of every symbol (the even bits of `word_i`) has no effect on any kernel.
- R4: Kernels 0 and 2 are the unmodified base vectors 0 and 1.
- R5: The two kernels that come from the same base vector are never bitwise complements of each other, for any input word.
- R6: The kernels depend only on the current `word_i`; no state is held.
- R7: A base vector of 16'b0001000011000011 gives the masked kernel 16'b0100010110010110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_i | input | 64 | Encrypted word; symbol k occupies bits 2k+1 (high digit) and 2k (low digit) |
| kernels_o | output | 64 | Four packed kernels; kernel k at bits 16k+15..16k |

## Verification
A wrong bit gather shows up as one kernel bit following the wrong input bit. A walking-one sweep over all 64 input positions exposes it at once: each high-digit position must light exactly one bit in each of two kernels, and each low-digit position must light none. A wrong mask value or a wrong mask order shows up in the XOR of the two kernels from one base, which must be 16'h5555 for every input word. The block is combinational, so any such fault is visible in the same cycle as the input that triggers it.

// File: rtl/coset_kgen_pkg.sv
// Package: shared sizing for the seeded coset kernel builder.
// Assumes two-bit symbols whose upper bit is never changed by the encoder.
package coset_kgen_pkg;
    localparam int SYM_W    = 2;   // bits per cell symbol
    localparam int NUM_SYM  = 32;  // symbols per input word
    localparam int KER_W    = 16;  // bits per kernel
    localparam int MASK_W   = 2;   // width of one repeating mask slice
    localparam int WORD_W   = SYM_W * NUM_SYM;
    localparam int NUM_BASE = NUM_SYM / KER_W;
    localparam int NUM_MASK = 2 ** (MASK_W - 1);  // top mask bit kept zero
    localparam int NUM_KER  = NUM_BASE * NUM_MASK;
endpackage

// File: rtl/coset_hi_gather.sv
// Module: coset_hi_gather
// Collects the upper digit of each symbol into one packed vector.
// Assumes symbol k sits at bits SYM_W*k+SYM_W-1 .. SYM_W*k of the word.
module coset_hi_gather
    import coset_kgen_pkg::*;
#(
    parameter int N_SYM = NUM_SYM
) (
    input  logic [SYM_W*N_SYM-1:0] word_i,
    output logic [N_SYM-1:0]       hi_o
);
    // One bit per symbol: pick its upper digit.
    for (genvar k = 0; k < N_SYM; k++) begin : g_sym
        assign hi_o[k] = word_i[SYM_W*k + SYM_W - 1];
    end
endmodule

// File: rtl/coset_mask_lane.sv
// Module: coset_mask_lane
// XORs one base vector with a fixed mask repeated over every slice.
// Assumes KER_W is a multiple of MASK_W; the mask top bit is zero.
module coset_mask_lane
    import coset_kgen_pkg::*;
#(
    parameter int            W    = KER_W,
    parameter logic [MASK_W-1:0] MASK = '0
) (
    input  logic [W-1:0] base_i,
    output logic [W-1:0] ker_o
);
    localparam int N_SLICE = W / MASK_W;

    // Each slice of the base vector receives the same mask.
    for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
        assign ker_o[MASK_W*s +: MASK_W] = base_i[MASK_W*s +: MASK_W] ^ MASK;
    end
endmodule

// File: rtl/coset_kernel_gen.sv
// Module: coset_kernel_gen (top)
// Builds NUM_KER kernels from the upper symbol digits of the input word.
// Kernel index = base*NUM_MASK + mask; mask value equals its index.
// Purely combinational; assumes the caller registers the word if needed.
module coset_kernel_gen
    import coset_kgen_pkg::*;
(
    input  logic [WORD_W-1:0]        word_i,
    output logic [NUM_KER*KER_W-1:0] kernels_o
);
    logic [NUM_SYM-1:0] hi_bits;

    // Gather seed material from the untouched upper digits.
    coset_hi_gather #(.N_SYM(NUM_SYM)) u_gather (
        .word_i (word_i),
        .hi_o   (hi_bits)
    );

    // One lane per (base, mask) pair, ordered base-major.
    for (genvar b = 0; b < NUM_BASE; b++) begin : g_base
        for (genvar m = 0; m < NUM_MASK; m++) begin : g_mask
            coset_mask_lane #(
                .W    (KER_W),
                .MASK (MASK_W'(m))
            ) u_lane (
                .base_i (hi_bits[KER_W*b +: KER_W]),
                .ker_o  (kernels_o[KER_W*(b*NUM_MASK+m) +: KER_W])
            );
        end
    end
endmodule

// File: rtl/coset_kernel_gen_chk.sv
// Module: coset_kernel_gen_chk
// Checks output relations of the kernel builder; bound to the top.
module coset_kernel_gen_chk
    import coset_kgen_pkg::*;
(
    input logic [WORD_W-1:0]        word_i,
    input logic [NUM_KER*KER_W-1:0] kernels_o
);
    for (genvar b = 0; b < NUM_BASE; b++) begin : g_b
        logic [KER_W-1:0] k_even, k_odd;
        assign k_even = kernels_o[KER_W*(2*b)   +: KER_W];
        assign k_odd  = kernels_o[KER_W*(2*b+1) +: KER_W];

        // Relate the two lanes of a base and the lane to the input word.
        always_comb begin
            p_mask_pair_r1: assert ((k_even ^ k_odd) == {(KER_W/2){2'b01}})
                else $error("R1 lane pair differs from repeated 01");
            p_no_compl_r5: assert ((k_even ^ k_odd) != {KER_W{1'b1}})
                else $error("R5 complementary kernels");
            p_base_r4: assert (k_even[0] == word_i[2*KER_W*b + 1])
                else $error("R4 base bit 0 mismatch");
            p_base_top_r2: assert (k_even[KER_W-1] == word_i[2*KER_W*b + 2*KER_W - 1])
                else $error("R2 base top bit mismatch");
        end
    end
endmodule

bind coset_kernel_gen coset_kernel_gen_chk u_chk (
    .word_i    (word_i),
    .kernels_o (kernels_o)
);

// File: tb/tb_coset_kernel_gen.sv
// Bench: sweeps walking-one words, pseudo-random words and the worked
// example, comparing each kernel to an arithmetic model.
module tb_coset_kernel_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] word_i;
    logic [63:0] kernels_o;
    int          total = 0;
    int          bad   = 0;
    bit          done  = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    coset_kernel_gen dut (.word_i(word_i), .kernels_o(kernels_o));

    // Model: kernel k from base k/2 and mask k%2 (R1, R2).
    function automatic logic [15:0] model_ker(input logic [63:0] w, input int k);
        logic [15:0] base;
        for (int j = 0; j < 16; j++) base[j] = w[2*(16*(k/2)+j)+1];
        return (k % 2 == 1) ? (base ^ 16'h5555) : base;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h word=%h", req, act, exp, word_i);
        end
    endtask

    // Applies a word and checks all four kernels after it settles.
    task automatic apply(input logic [63:0] w, input string req);
        @(negedge clk);
        word_i = w;
        #1;
        for (int k = 0; k < 4; k++) check(req, kernels_o[16*k +: 16], model_ker(w, k));
    endtask

    initial begin
        logic [63:0] lfsr;
        logic [63:0] keep [4];
        word_i = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle/zero word: R4 bases zero, R1 masked lanes 5555.
        apply(64'd0, "R4");
        check("R1", kernels_o[31:16], 16'h5555);
        // Walking one over every bit: R2 placement and R3 low digits ignored.
        for (int i = 0; i < 64; i++) begin
            apply(64'd1 << i, "R2");
            if (i % 2 == 0) begin
                check("R3", kernels_o[15:0], 16'h0);
                check("R3", kernels_o[47:32], 16'h0);
            end
        end
        // Pseudo-random words; R3 toggles low digits, R6 revisits words.
        lfsr = 64'hACE1_2468_1357_BDF0;
        for (int n = 0; n < 500; n++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            apply(lfsr, "R1");
            for (int k = 0; k < 4; k++) keep[k] = {48'd0, kernels_o[16*k +: 16]};
            check("R5", (kernels_o[15:0] ^ kernels_o[31:16]) == 16'hFFFF ? 16'h1 : 16'h0, 16'h0);
            apply(lfsr ^ 64'h5555_5555_5555_5555, "R3");
            for (int k = 0; k < 4; k++) check("R3", kernels_o[16*k +: 16], keep[k][15:0]);
            apply(~lfsr, "R6");
            apply(lfsr, "R6");
            for (int k = 0; k < 4; k++) check("R6", kernels_o[16*k +: 16], keep[k][15:0]);
        end
        // Worked example: base 0001000011000011 in both halves (R7).
        begin
            logic [63:0] w;
            logic [15:0] b;
            b = 16'b0001000011000011;
            w = '0;
            for (int j = 0; j < 16; j++) begin
                w[2*j+1]      = b[j];
                w[2*(16+j)+1] = b[j];
            end
            apply(w, "R7");
            check("R7", kernels_o[31:16], 16'b0100010110010110);
            check("R7", kernels_o[63:48], 16'b0100010110010110);
        end
        done = 1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule